// File: doc/BRIEF.md
# Serial Path-Overhead Byte Writer

This block sits outside a serial path-overhead input port and loads one chosen overhead byte, such as the signal label, into it once per frame. The port supplies a clock, a frame strobe and an enable strobe. The writer samples the two strobes on each rising edge of that clock. When it sees both strobes high, and its own byte source reports a valid value, it takes a copy of the byte. It then lets a fixed number of clock periods pass. These periods cover the overhead bytes that come before the target byte in the frame.

After the skip, the writer sends the copied byte on a single serial line, most significant bit first. It changes the line on falling edges, so the port can capture each bit cleanly on the next rising edge. After the eighth bit it goes back to watching the strobes for the next frame. A busy flag is high while a transfer is in progress. The target byte's position is set by a parameter giving the number of bytes to skip; its default of two places the target in the third overhead byte.

Top module: `pohw_serial_writer`

## Requirements
- R1: While `rst` is high at a rising edge, the writer returns to idle. After that edge `busy` is 0, and `serOut` is 0 from the following falling edge.
- R2: A transfer starts at a rising edge only if the writer is idle and `frameStb`, `enableStb` and `byteValid` are all 1 at that edge. If any one of them is 0, the writer stays idle.
- R3: After the start edge, 16 further rising edges pass (two bytes of 8 bits each) before any data is driven. During this time `busy` is 1 and `serOut` is 0.
- R4: The most significant bit of the byte is driven on the falling edge that follows the 16th rising edge after the start edge. It is therefore valid at the 17th rising edge.
- R5: The remaining seven bits follow on the next seven consecutive falling edges, in order from bit 6 down to bit 0. Bit 0 is therefore valid at the 24th rising edge after the start edge.
- R6: The byte is captured at the start edge. Changes on `byteIn` or `byteValid` during a transfer do not alter the bits that are sent.
- R7: Strobes seen during a transfer neither restart it nor shift its timing.
- R8: `busy` falls at the 24th rising edge after the start edge. The earliest edge at which a new start can be accepted is the 25th.
- R9: `serOut` is 0 on every falling edge where no data bit is due.
- R10: A reset in the middle of a transfer aborts it. No further data bits are sent, and the writer waits for a fresh start condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; strobes are sampled on its rising edge, data is launched on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| frameStb | input | 1 | Frame strobe from the port |
| enableStb | input | 1 | Enable strobe from the port |
| byteIn | input | 8 | Value of the overhead byte to write |
| byteValid | input | 1 | Marks `byteIn` as ready to be loaded |
| serOut | output | 1 | Serial data to the port, MSB first |
| busy | output | 1 | High while a transfer is in progress |

## Verification
A wrong skip count shows up at once as a one-bit slip: the MSB appears one rising edge early or late, and `busy` falls at the wrong edge in the same cycle. A latch that follows `byteIn` instead of holding its copy shows up as a wrong bit as soon as the input changes in the middle of a transfer. A start decision that ignores a strobe, or that accepts a start while busy, shows up within one clock on `busy`. It then shows up as a shifted bit pattern about 17 edges later. The bench compares both outputs on every cycle against a cycle model, so any such error is reported on the cycle where it first appears.

// File: rtl/pohw_pkg.sv
package pohw_pkg;

  // Writer phases: waiting for strobes, skipping earlier overhead bytes, shifting out
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_SHIFT = 2'd2
  } wrState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture byteIn at this rising edge
    logic shift;   // advance the shift register at this rising edge
    logic active;  // a data bit is due at the coming falling edge
  } wrCtl_t;

endpackage

// File: rtl/pohw_ctrl.sv
module pohw_ctrl
  import pohw_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SKIP_BYTES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   frameStb,
  input  logic   enableStb,
  input  logic   byteValid,
  output wrCtl_t ctl,
  output logic   busy
);

  localparam int SKIP_CYC = SKIP_BYTES * BYTE_W;
  localparam int SKIP_W   = $clog2(SKIP_CYC + 1);
  localparam int BIT_W    = $clog2(BYTE_W + 1);
  localparam logic [SKIP_W-1:0] SKIP_LAST = SKIP_W'(SKIP_CYC - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BYTE_W - 1);

  wrState_t state, stateNext;
  logic [SKIP_W-1:0] skipCnt, skipCntNext;
  logic [BIT_W-1:0]  bitCnt, bitCntNext;
  logic startHit;

  assign startHit = frameStb & enableStb & byteValid;

  always_comb begin
    stateNext   = state;
    skipCntNext = skipCnt;
    bitCntNext  = bitCnt;
    unique case (state)
      ST_IDLE: begin
        skipCntNext = '0;
        bitCntNext  = '0;
        if (startHit) stateNext = ST_SKIP;
      end
      ST_SKIP: begin
        if (skipCnt == SKIP_LAST) begin
          stateNext   = ST_SHIFT;
          skipCntNext = '0;
          bitCntNext  = '0;
        end else begin
          skipCntNext = skipCnt + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (bitCnt == BIT_LAST) begin
          stateNext  = ST_IDLE;
          bitCntNext = '0;
        end else begin
          bitCntNext = bitCnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      skipCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNext;
      skipCnt <= skipCntNext;
      bitCnt  <= bitCntNext;
    end
  end

  always_comb begin
    ctl.load   = (state == ST_IDLE) & startHit;
    ctl.shift  = (state == ST_SHIFT);
    ctl.active = (state == ST_SHIFT);
  end

  assign busy = (state != ST_IDLE);

  // Assertions
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !startHit) |=> (state == ST_IDLE)); // R2
  AST_SKIP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> (skipCnt <= SKIP_LAST)); // R3
  AST_SKIP_TO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP && skipCnt == SKIP_LAST) |=> (state == ST_SHIFT && bitCnt == '0)); // R4
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && bitCnt != BIT_LAST) |=> (state == ST_SHIFT && bitCnt == $past(bitCnt) + 1'b1)); // R5
  AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && bitCnt == BIT_LAST) |=> (state == ST_IDLE)); // R8
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ctl.load); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && skipCnt == '0 && bitCnt == '0)); // R10

endmodule

// File: rtl/pohw_datapath.sv
module pohw_datapath
  import pohw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  wrCtl_t            ctl,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              serOut
);

  logic [BYTE_W-1:0] shiftReg;

  // Byte copy: captured on start, then moved toward the MSB once per bit
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (ctl.load) begin
      shiftReg <= byteIn;
    end else if (ctl.shift) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
    end
  end

  // Launch register: updates on the falling edge so the port captures on the rising edge
  always_ff @(negedge clk) begin
    if (rst) begin
      serOut <= 1'b0;
    end else begin
      serOut <= ctl.active & shiftReg[BYTE_W-1];
    end
  end

  // Assertions
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!ctl.load && !ctl.shift) |=> $stable(shiftReg)); // R6
  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (rst)
    (!ctl.active && !$past(ctl.active)) |-> !serOut); // R9

endmodule

// File: rtl/pohw_serial_writer.sv
module pohw_serial_writer
  import pohw_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SKIP_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameStb,
  input  logic              enableStb,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              byteValid,
  output logic              serOut,
  output logic              busy
);

  wrCtl_t ctl;

  pohw_ctrl #(
    .BYTE_W     (BYTE_W),
    .SKIP_BYTES (SKIP_BYTES)
  ) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .frameStb  (frameStb),
    .enableStb (enableStb),
    .byteValid (byteValid),
    .ctl       (ctl),
    .busy      (busy)
  );

  pohw_datapath #(
    .BYTE_W (BYTE_W)
  ) uData (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .byteIn (byteIn),
    .serOut (serOut)
  );

endmodule

// File: tb/tb_pohw_serial_writer.sv
module tb_pohw_serial_writer;

  localparam int SKIP  = 16;        // two earlier bytes of 8 bits
  localparam int LAST  = SKIP + 8;  // edge at which bit 0 is valid and busy falls
  localparam int IDLEP = LAST + 1;  // model position meaning idle

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frameStb = 1'b0, enableStb = 1'b0, byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic       serOut, busy;

  int checks = 0, fails = 0;
  int mPos = IDLEP;
  logic [7:0] mByte = 8'h00;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  pohw_serial_writer dut (
    .clk(clk), .rst(rst), .frameStb(frameStb), .enableStb(enableStb),
    .byteIn(byteIn), .byteValid(byteValid), .serOut(serOut), .busy(busy)
  );

  function automatic logic expBusy(int p);
    return p < LAST;
  endfunction

  function automatic logic expSer(int p, logic [7:0] b);
    if (p > SKIP && p <= LAST) return b[LAST - p];
    return 1'b0;
  endfunction

  function automatic string tagFor(int p);
    if (p <= SKIP) return "R3";
    if (p == SKIP + 1) return "R4";
    if (p < LAST) return "R5";
    if (p == LAST) return "R8";
    return "R9";
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b time=%0t", req, what, act, exp, $time);
    end
  endtask

  // One rising edge: advance the model with the inputs held before it, then compare
  task automatic tick(string forceTag = "");
    string t;
    @(posedge clk);
    if (rst) mPos = IDLEP;
    else if (mPos >= LAST) begin
      if (frameStb && enableStb && byteValid) begin
        mPos = 0;
        mByte = byteIn;
      end else mPos = IDLEP;
    end else mPos++;
    #1;
    t = (forceTag != "") ? forceTag : tagFor(mPos);
    check(t, busy, expBusy(mPos), "busy");
    check(t, serOut, expSer(mPos, mByte), "serOut");
  endtask

  task automatic setIn(logic f, logic e, logic v, logic [7:0] b);
    frameStb = f; enableStb = e; byteValid = v; byteIn = b;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    // R1: reset state
    tick("R1"); tick("R1");
    #5;
    check("R1", serOut, 1'b0, "serOut after reset falling edge");
    check("R1", busy, 1'b0, "busy in reset");
    @(negedge clk); #1;
    rst = 0;

    // R2: partial start conditions leave the writer idle
    setIn(1, 1, 0, 8'hFF); tick("R2");
    setIn(1, 0, 1, 8'hFF); tick("R2");
    setIn(0, 1, 1, 8'hFF); tick("R2");
    setIn(0, 0, 0, 8'hFF); tick("R2");
    check("R2", busy, 1'b0, "busy after partial strobes");

    // R4 R5 R6 R7: directed byte, input churn and strobe spam mid transfer
    setIn(1, 1, 1, 8'hA5); tick("R2");
    check("R2", busy, 1'b1, "busy after full start");
    for (int i = 0; i < LAST + 1; i++) begin
      setIn(1, 1, 1, 8'h3C ^ 8'(i));  // R6, R7: new values and strobes must not matter
      tick();
      if (i == SKIP) check("R4", serOut, 1'b1, "MSB of A5");
      if (i == LAST - 1) check("R5", serOut, 1'b1, "LSB of A5");
    end
    // R8: strobes held high restart exactly at the 25th edge
    check("R8", busy, 1'b1, "restart at 25th edge");
    setIn(0, 0, 0, 8'h00);
    for (int i = 0; i < LAST + 2; i++) tick();

    // R10: reset in the skip phase aborts the transfer
    setIn(1, 1, 1, 8'hFF); tick();
    setIn(0, 0, 0, 8'hFF);
    for (int i = 0; i < 5; i++) tick();
    rst = 1; tick("R10");
    rst = 0;
    for (int i = 0; i < LAST + 2; i++) tick("R10");
    check("R10", busy, 1'b0, "idle after abort");

    // Edge bytes
    setIn(1, 1, 1, 8'h80); tick();
    setIn(0, 0, 0, 8'h00);
    for (int i = 0; i < LAST + 1; i++) tick();
    setIn(1, 1, 1, 8'h01); tick();
    setIn(0, 0, 0, 8'h00);
    for (int i = 0; i < LAST + 1; i++) tick();

    // Constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      setIn(($urandom % 4) == 0, ($urandom % 3) != 0, ($urandom % 5) != 0, 8'($urandom));
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule